// File: doc/BRIEF.md
# Inter-processor interrupt unit

This block lets processors in a cluster interrupt one another. Each of `NCPU` processors (1 to 31) owns two interrupt kinds: an "other" interrupt that any processor can raise toward any set of processors, and a "self" interrupt that a processor raises on itself. Each kind has one pending bit and one mask bit per processor. Software uses write-one-to-act registers to raise, acknowledge, mask and unmask them. It uses either the requester's own view, selected by the processor index that comes with each access, or an explicit per-processor window that reaches any processor's state.

The unit also serves the per-processor event register. A read of that register returns the requester's highest-priority pending work. A hardware line forwarded from the interrupt aggregator comes first. After it come the unmasked pending inter-processor interrupts. Handing out an inter-processor interrupt through the event register masks it at once, so it is not reported again until software unmasks it. The bus has `NPORT` independent access ports, each carrying 32-bit data and a requester index, so several processors can act in the same cycle. Each port's read data is registered and appears one clock after the read strobe. A per-processor interrupt output is raised whenever that processor has something to collect.

Top module: `ipi_unit`

## Requirements
- R1: After reset, on every processor both kinds are not pending and both are masked, `irq_o` is low, and an event read returns 0.
- R2: A write to 0x2008 raises "other" pending on every processor n whose data bit n is set (n < NCPU); several targets may be hit in one write. Data bit 31 raises "self" pending on the requesting processor.
- R3: Writing ones to 0x200C clears the requester's pending bits, with bit 0 for "other" and bit 31 for "self". A read of 0x200C returns the requester's pending state in the same bit positions.
- R4: Writing ones to 0x2024 sets the requester's mask bits and writing ones to 0x2028 clears them (bit 0 "other", bit 31 "self"). A read of either address returns the mask in the same positions. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R5: A read of 0x2004 returns {type[31:16], number[15:0]}. A valid hardware line gives type 1 with its number. Otherwise an unmasked pending "other" gives 0x00040001, then an unmasked pending "self" gives 0x00040002. Otherwise the read returns 0. Read data appears one clock after the read strobe.
- R6: Reporting an inter-processor interrupt through 0x2004 sets that kind's mask bit and leaves its pending bit alone. Reporting a hardware line changes no mask.
- R7: The window at 0x5000 + n*128 acts on processor n, whoever the requester is. Offset 0x08 raises pending, 0x0C clears pending, 0x24 sets the mask and 0x28 clears the mask, using bit 0 and bit 31 as above. Reads at 0x08 or 0x0C return pending, and reads at 0x24 or 0x28 return the mask.
- R8: When a raise and an acknowledge reach the same pending bit in the same cycle, the bit ends up pending.
- R9: `irq_o[n]`, updated on each clock, is high when processor n's hardware line is valid or it has a pending unmasked interrupt.
- R10: Bits 30 down to NCPU of a 0x2008 write are ignored, and a window index of NCPU or above changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | NPORT | Write strobe per port |
| bus_rd | input | NPORT | Read strobe per port |
| bus_addr | input | NPORT*16 | Byte address per port |
| bus_wdata | input | NPORT*32 | Write data per port |
| bus_cpu | input | NPORT*CPU_W | Requesting processor index per port |
| bus_rdata | output | NPORT*32 | Registered read data per port |
| hw_vld | input | NCPU | A hardware line is pending for this processor |
| hw_num | input | NCPU*16 | Number of that hardware line |
| irq_o | output | NCPU | Interrupt request per processor |

## Verification
Every subset of target processors is written to the raise register, and each processor's pending bit is then read back through its own window. This separates a wrong bit-to-processor mapping from a leak into the "self" bit. Event reads are tried with both kinds pending and unmasked, with a hardware line present, and with everything masked. These runs distinguish priority order, the automatic masking, and the rule that hardware delivery leaves masks alone. Two ports are driven in the same cycle so that the raise-versus-acknowledge and set-versus-clear outcomes can be observed, and out-of-range bits and window indices are written to show they change nothing.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // Current-processor register view
  localparam logic [15:0] OFS_EVENT = 16'h2004;
  localparam logic [15:0] OFS_SEND  = 16'h2008;
  localparam logic [15:0] OFS_ACK   = 16'h200C;
  localparam logic [15:0] OFS_MSET  = 16'h2024;
  localparam logic [15:0] OFS_MCLR  = 16'h2028;
  // Explicit per-processor windows, 128 bytes apart
  localparam logic [15:0] WIN_BASE  = 16'h5000;
  localparam logic [6:0]  WOFS_SET  = 7'h08;
  localparam logic [6:0]  WOFS_CLR  = 7'h0C;
  localparam logic [6:0]  WOFS_MSET = 7'h24;
  localparam logic [6:0]  WOFS_MCLR = 7'h28;
  // Event word fields
  localparam logic [15:0] KIND_HW   = 16'd1;
  localparam logic [15:0] KIND_IPI  = 16'd4;
  localparam logic [15:0] NUM_OTHER = 16'd1;
  localparam logic [15:0] NUM_SELF  = 16'd2;

  // Per-processor request bundle; bit 0 = other, bit 1 = self
  typedef struct packed {
    logic [1:0] raise;
    logic [1:0] drop;
    logic [1:0] mask_on;
    logic [1:0] mask_off;
  } ipi_req_t;

  function automatic logic [1:0] kind_bits(logic [31:0] w);
    return {w[31], w[0]};
  endfunction

  function automatic logic [31:0] kind_word(logic [1:0] k);
    return {k[1], 30'd0, k[0]};
  endfunction

  function automatic logic [8:0] win_slot(logic [15:0] a);
    logic [15:0] rel;
    rel = a - WIN_BASE;
    return rel[15:7];
  endfunction

  function automatic logic win_hit(logic [15:0] a, logic [8:0] slot);
    return (a >= WIN_BASE) && (win_slot(a) == slot);
  endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode #(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                                wr,
  input  logic [15:0]                         addr,
  input  logic [31:0]                         wdata,
  input  logic [CPU_W-1:0]                    cpu,
  output ipi_pkg::ipi_req_t [NCPU-1:0]        req
);
  import ipi_pkg::*;

  logic [1:0] kb;
  logic       wdata_unused;
  assign kb           = kind_bits(wdata);
  assign wdata_unused = ^wdata;

  always_comb begin
    req = '0;
    for (int c = 0; c < NCPU; c++) begin
      logic own;
      logic win;
      own = wr && (cpu == CPU_W'(c));
      win = wr && win_hit(addr, 9'(c));
      if (wr && addr == OFS_SEND) begin
        req[c].raise[0] = wdata[c];
        req[c].raise[1] = own & wdata[31];
      end
      if (own && addr == OFS_ACK)  req[c].drop     = kb;
      if (own && addr == OFS_MSET) req[c].mask_on  = kb;
      if (own && addr == OFS_MCLR) req[c].mask_off = kb;
      if (win) begin
        case (addr[6:0])
          WOFS_SET:  req[c].raise    = req[c].raise | kb;
          WOFS_CLR:  req[c].drop     = kb;
          WOFS_MSET: req[c].mask_on  = kb;
          WOFS_MCLR: req[c].mask_off = kb;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port #(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                        rd,
  input  logic [15:0]                 addr,
  input  logic [CPU_W-1:0]            cpu,
  input  logic [NCPU-1:0]             hw_vld,
  input  logic [NCPU-1:0][15:0]       hw_num,
  input  logic [NCPU-1:0][1:0]        pend,
  input  logic [NCPU-1:0][1:0]        mask,
  output logic [31:0]                 rdata_n,
  output logic [NCPU-1:0][1:0]        auto_on
);
  import ipi_pkg::*;

  always_comb begin
    rdata_n = '0;
    auto_on = '0;
    if (rd) begin
      for (int c = 0; c < NCPU; c++) begin
        logic [1:0] live;
        live = pend[c] & ~mask[c];
        if (cpu == CPU_W'(c)) begin
          case (addr)
            OFS_EVENT: begin
              if (hw_vld[c]) begin
                rdata_n = {KIND_HW, hw_num[c]};
              end else if (live[0]) begin
                rdata_n       = {KIND_IPI, NUM_OTHER};
                auto_on[c][0] = 1'b1;
              end else if (live[1]) begin
                rdata_n       = {KIND_IPI, NUM_SELF};
                auto_on[c][1] = 1'b1;
              end
            end
            OFS_ACK:            rdata_n = kind_word(pend[c]);
            OFS_MSET, OFS_MCLR: rdata_n = kind_word(mask[c]);
            default: ;
          endcase
        end
        if (win_hit(addr, 9'(c))) begin
          case (addr[6:0])
            WOFS_SET, WOFS_CLR:   rdata_n = kind_word(pend[c]);
            WOFS_MSET, WOFS_MCLR: rdata_n = kind_word(mask[c]);
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_state.sv
module ipi_cpu_state (
  input  logic              clk,
  input  logic              rst,
  input  ipi_pkg::ipi_req_t req,
  input  logic [1:0]        auto_on,
  input  logic              hw_vld,
  output logic [1:0]        pend,
  output logic [1:0]        mask,
  output logic              irq
);
  logic [1:0] pend_n;
  logic [1:0] mask_n;

  always_comb begin
    pend_n = (pend & ~req.drop) | req.raise;
    mask_n = (mask & ~req.mask_off) | req.mask_on | auto_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 2'b00;
      mask <= 2'b11;
      irq  <= 1'b0;
    end else begin
      pend <= pend_n;
      mask <= mask_n;
      irq  <= hw_vld | (|(pend_n & ~mask_n));
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_chk
    p_raise_wins_r8: assert property (@(posedge clk) disable iff (rst)
      req.raise[k] |=> pend[k]);
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (req.drop[k] && !req.raise[k]) |=> !pend[k]);
    p_mask_on_r4: assert property (@(posedge clk) disable iff (rst)
      (req.mask_on[k] || auto_on[k]) |=> mask[k]);
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int NCPU  = 4,
  parameter int NPORT = 2,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        bus_wr,
  input  logic [NPORT-1:0]        bus_rd,
  input  logic [NPORT*16-1:0]     bus_addr,
  input  logic [NPORT*32-1:0]     bus_wdata,
  input  logic [NPORT*CPU_W-1:0]  bus_cpu,
  output logic [NPORT*32-1:0]     bus_rdata,
  input  logic [NCPU-1:0]         hw_vld,
  input  logic [NCPU*16-1:0]      hw_num,
  output logic [NCPU-1:0]         irq_o
);
  import ipi_pkg::*;

  ipi_req_t [NPORT-1:0][NCPU-1:0] req_p;
  logic [NPORT-1:0][NCPU-1:0][1:0] auto_p;
  logic [NPORT-1:0][31:0]          rdata_n;
  ipi_req_t [NCPU-1:0]             req_m;
  logic [NCPU-1:0][1:0]            auto_m;
  logic [NCPU-1:0][1:0]            pend_a;
  logic [NCPU-1:0][1:0]            mask_a;
  logic [NCPU-1:0][15:0]           hw_num_a;

  assign hw_num_a = hw_num;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ipi_port_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) i_dec (
      .wr    (bus_wr[p]),
      .addr  (bus_addr[p*16 +: 16]),
      .wdata (bus_wdata[p*32 +: 32]),
      .cpu   (bus_cpu[p*CPU_W +: CPU_W]),
      .req   (req_p[p])
    );
    ipi_read_port #(.NCPU(NCPU), .CPU_W(CPU_W)) i_rdp (
      .rd      (bus_rd[p]),
      .addr    (bus_addr[p*16 +: 16]),
      .cpu     (bus_cpu[p*CPU_W +: CPU_W]),
      .hw_vld  (hw_vld),
      .hw_num  (hw_num_a),
      .pend    (pend_a),
      .mask    (mask_a),
      .rdata_n (rdata_n[p]),
      .auto_on (auto_p[p])
    );
    always_ff @(posedge clk) begin
      if (rst) bus_rdata[p*32 +: 32] <= '0;
      else     bus_rdata[p*32 +: 32] <= rdata_n[p];
    end
  end

  always_comb begin
    req_m  = '0;
    auto_m = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int c = 0; c < NCPU; c++) begin
        req_m[c]  = ipi_req_t'(req_m[c] | req_p[p][c]);
        auto_m[c] = auto_m[c] | auto_p[p][c];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    ipi_cpu_state i_st (
      .clk     (clk),
      .rst     (rst),
      .req     (req_m[c]),
      .auto_on (auto_m[c]),
      .hw_vld  (hw_vld[c]),
      .pend    (pend_a[c]),
      .mask    (mask_a[c]),
      .irq     (irq_o[c])
    );
  end

  // Per-port view of the requester's hardware line and live interrupts
  logic [NPORT-1:0] port_hw;
  logic [NPORT-1:0] port_live;
  always_comb begin
    port_hw   = '0;
    port_live = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int c = 0; c < NCPU; c++) begin
        if (bus_cpu[p*CPU_W +: CPU_W] == CPU_W'(c)) begin
          port_hw[p]   = hw_vld[c];
          port_live[p] = |(pend_a[c] & ~mask_a[c]);
        end
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    p_hw_first_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_rd[p] && bus_addr[p*16 +: 16] == OFS_EVENT && port_hw[p])
      |=> bus_rdata[p*32+16 +: 16] == KIND_HW);
    p_ipi_event_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_rd[p] && bus_addr[p*16 +: 16] == OFS_EVENT && !port_hw[p] && port_live[p])
      |=> bus_rdata[p*32+16 +: 16] == KIND_IPI);
  end
endmodule

// File: tb/test_ipi_unit.sv
module test_ipi_unit;
  localparam int NCPU = 4;
  localparam int NPORT = 2;
  localparam int CW = 2;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NPORT-1:0]      bus_wr, bus_rd;
  logic [NPORT*16-1:0]   bus_addr;
  logic [NPORT*32-1:0]   bus_wdata;
  logic [NPORT*CW-1:0]   bus_cpu;
  wire  [NPORT*32-1:0]   bus_rdata;
  logic [NCPU-1:0]       hw_vld;
  logic [NCPU*16-1:0]    hw_num;
  wire  [NCPU-1:0]       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] d;

  ipi_unit #(.NCPU(NCPU), .NPORT(NPORT)) i_ipi_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .hw_vld(hw_vld), .hw_num(hw_num), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] win(int c, logic [6:0] o);
    return 16'h5000 + 16'(c * 128) + 16'(o);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put_wr(int p, int c, logic [15:0] a, logic [31:0] v);
    bus_wr[p] = 1'b1;
    bus_addr[p*16 +: 16] = a;
    bus_wdata[p*32 +: 32] = v;
    bus_cpu[p*CW +: CW] = CW'(c);
  endtask

  task automatic go();
    @(negedge clk);
    bus_wr = '0;
    bus_rd = '0;
  endtask

  task automatic wr(int c, logic [15:0] a, logic [31:0] v);
    put_wr(0, c, a, v);
    go();
  endtask

  task automatic rd(int p, int c, logic [15:0] a, output logic [31:0] v);
    bus_rd[p] = 1'b1;
    bus_addr[p*16 +: 16] = a;
    bus_cpu[p*CW +: CW] = CW'(c);
    go();
    v = bus_rdata[p*32 +: 32];
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_wr = '0; bus_rd = '0; bus_addr = '0; bus_wdata = '0; bus_cpu = '0;
    hw_vld = '0; hw_num = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      rd(0, c, 16'h200C, d); chk("R1 pending", d, 32'h0);
      rd(1, c, 16'h2024, d); chk("R1 mask", d, 32'h80000001);
      rd(0, c, 16'h2004, d); chk("R1 event", d, 32'h0);
    end

    // R2/R7: every target subset, read back through each window
    for (int s = 0; s < 16; s++) begin
      wr(s % NCPU, 16'h2008, 32'(s));
      for (int c = 0; c < NCPU; c++) begin
        rd(c % NPORT, 0, win(c, 7'h08), d);
        chk("R2 R7 subset pending", d, ((s >> c) & 1) != 0 ? 32'h1 : 32'h0);
      end
      for (int c = 0; c < NCPU; c++) wr(0, win(c, 7'h0C), 32'h80000001);
    end

    // R2/R3: self raise only hits the requester, then ack clears it
    for (int c = 0; c < NCPU; c++) begin
      wr(c, 16'h2008, 32'h80000000);
      for (int k = 0; k < NCPU; k++) begin
        rd(0, k, 16'h200C, d);
        chk("R2 self pending", d, (k == c) ? 32'h80000000 : 32'h0);
      end
      wr(c, 16'h200C, 32'h80000000);
      rd(1, c, 16'h200C, d); chk("R3 ack clears", d, 32'h0);
    end

    // R4: mask set / clear per bit
    for (int c = 0; c < NCPU; c++) begin
      wr(c, 16'h2028, 32'h80000001);
      rd(0, c, 16'h2024, d); chk("R4 mask cleared", d, 32'h0);
      wr(c, 16'h2024, 32'h1);
      rd(0, c, 16'h2028, d); chk("R4 mask other", d, 32'h1);
      wr(c, 16'h2024, 32'h80000000);
      rd(0, c, 16'h2024, d); chk("R4 mask both", d, 32'h80000001);
    end
    // R4: set and clear in the same cycle, set wins
    wr(1, 16'h2028, 32'h80000001);
    put_wr(0, 1, 16'h2024, 32'h1);
    put_wr(1, 1, 16'h2028, 32'h80000001);
    go();
    rd(0, 1, 16'h2024, d); chk("R4 set wins", d, 32'h1);

    // R5/R6/R7/R9 on processor 2
    wr(2, 16'h2028, 32'h80000001);
    wr(0, win(2, 7'h08), 32'h80000001);
    chk("R9 irq live", 32'(irq_o[2]), 32'h1);
    rd(1, 2, 16'h2004, d); chk("R5 other first", d, 32'h00040001);
    rd(0, 2, 16'h2024, d); chk("R6 other masked", d, 32'h1);
    rd(1, 2, 16'h2004, d); chk("R5 self next", d, 32'h00040002);
    rd(0, 2, 16'h2024, d); chk("R6 self masked", d, 32'h80000001);
    rd(1, 2, 16'h2004, d); chk("R5 empty", d, 32'h0);
    rd(0, 2, 16'h200C, d); chk("R6 pending kept", d, 32'h80000001);
    chk("R9 irq masked", 32'(irq_o[2]), 32'h0);

    // R5/R6/R9: hardware line first, no mask change
    wr(0, win(2, 7'h28), 32'h80000001);
    hw_vld[2] = 1'b1;
    hw_num[2*16 +: 16] = 16'h0123;
    rd(0, 2, 16'h2004, d); chk("R5 hw first", d, 32'h00010123);
    rd(0, 2, 16'h2024, d); chk("R6 hw no mask", d, 32'h0);
    hw_vld[2] = 1'b0;
    rd(1, 2, 16'h2004, d); chk("R5 ipi after hw", d, 32'h00040001);
    wr(2, 16'h200C, 32'h80000001);
    wr(2, 16'h2024, 32'h80000001);
    chk("R9 irq idle", 32'(irq_o), 32'h0);
    hw_vld[3] = 1'b1;
    @(negedge clk);
    chk("R9 irq hw", 32'(irq_o), 32'h8);
    hw_vld[3] = 1'b0;
    @(negedge clk);

    // R8: raise and ack on the same bit in one cycle
    for (int pre = 0; pre < 2; pre++) begin
      if (pre != 0) wr(0, 16'h2008, 32'h8);
      put_wr(0, 0, 16'h2008, 32'h8);
      put_wr(1, 3, 16'h200C, 32'h1);
      go();
      rd(0, 3, win(3, 7'h08), d); chk("R8 raise wins", d, 32'h1);
      wr(3, 16'h200C, 32'h1);
      rd(0, 3, win(3, 7'h0C), d); chk("R3 ack alone", d, 32'h0);
    end

    // R10: out-of-range bits and window index
    wr(0, 16'h2008, 32'h7FFFFFF0);
    wr(0, win(NCPU, 7'h08), 32'h80000001);
    wr(0, win(NCPU, 7'h28), 32'h80000001);
    for (int c = 0; c < NCPU; c++) begin
      rd(0, c, 16'h200C, d); chk("R10 no pending", d, 32'h0);
    end
    rd(0, 0, 16'h2024, d); chk("R10 mask kept", d, 32'h80000001);

    summary();
    $finish;
  end
endmodule